// File: doc/BRIEF.md
# Register-Relative Load/Store Address Unit

This unit decodes the data-movement group of a small 16-bit instruction set. It handles three operations: a load from memory at a base register plus a 6-bit offset, a store to memory at the same kind of address, and an address computation that adds a 9-bit offset to the program counter and writes the sum to a register without touching memory. The offsets are two's-complement. The program counter used here is the one already incremented past the instruction, so it equals the instruction's own address plus one.

In the issue cycle (`instrValid` high) the unit selects the register-file ports from the instruction fields and forms the memory address. It drives the memory read or write strobe in that same cycle. The memory is synchronous: read data arrives one cycle after the read strobe. Writeback comes out of one registered stage. Loads and PC-relative results therefore both appear the cycle after issue, carrying the destination index and the negative, zero and positive condition flags of the written value.

Top module: `ldst_agen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `memRead`, `memWrite` and `wbEn` are all 0.
- R2: For opcode 0110 in bits [15:12], in the issue cycle `regSelA` equals bits [8:6], `memRead` is 1, `memWrite` is 0, and `memAddr` equals `regDataA` plus the sign-extended bits [5:0], modulo 2^16.
- R3: The cycle after an opcode-0110 issue, `wbEn` is 1, `wbReg` equals the issued bits [11:9], and `wbData` equals the word the memory returns for that address.
- R4: For opcode 0111, in the issue cycle `regSelB` equals bits [11:9], `memWrite` is 1, `memRead` is 0, `memAddr` is formed as in R2, and `memWdata` equals `regDataB`. In the following cycle `wbEn` is 0.
- R5: For opcode 1110, `memRead` and `memWrite` stay 0 in the issue cycle. In the next cycle `wbEn` is 1, `wbReg` equals bits [11:9], and `wbData` equals `nextPc` plus the sign-extended bits [8:0], modulo 2^16.
- R6: Offsets with their top bit set are negative: 6'b100000 adds -32 and 9'h100 adds -256. Sums wrap modulo 2^16.
- R7: Whenever `wbEn` is 1, exactly one of `ccNeg`, `ccZero`, `ccPos` is 1. `ccNeg` is bit 15 of `wbData`, `ccZero` means `wbData` is zero, and `ccPos` covers the remaining values.
- R8: Any other opcode, or `instrValid` at 0, leaves `memRead` and `memWrite` at 0 in that cycle and `wbEn` at 0 in the next.
- R9: Issues in consecutive cycles each produce their own writeback, one cycle after their own issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| nextPc | input | 16 | Address of the instruction plus one |
| regSelA | output | 3 | Register-file read select for the base register |
| regSelB | output | 3 | Register-file read select for the store source |
| regDataA | input | 16 | Value of the register picked by `regSelA` |
| regDataB | input | 16 | Value of the register picked by `regSelB` |
| memAddr | output | 16 | Memory word address |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid one cycle after `memRead` |
| wbEn | output | 1 | Register writeback enable |
| wbReg | output | 3 | Writeback destination index |
| wbData | output | 16 | Writeback value |
| ccNeg | output | 1 | Negative flag of `wbData` |
| ccZero | output | 1 | Zero flag of `wbData` |
| ccPos | output | 1 | Positive flag of `wbData` |

## Verification
The assertions watch several rules on every cycle. A PC-relative or undecoded instruction never drives a memory strobe. A store or an idle cycle is never followed by a writeback. Every writeback traces back to a valid issue one cycle earlier, and its flags are one-hot. The PC-relative sum must match the issued operands. Two things only the bench's scenarios can show: that the computed addresses, including negative and wrapping offsets, reach the correct memory word, and that a loaded value returns intact with the right destination and flags, alone and back-to-back with other operations.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int XLEN   = 16;
  localparam int RIDX_W = 3;
  localparam int OPC_W  = 4;
  localparam int OFFB_W = 6;
  localparam int OFFP_W = 9;

  localparam logic [OPC_W-1:0] OP_LDREG  = 4'b0110;
  localparam logic [OPC_W-1:0] OP_STREG  = 4'b0111;
  localparam logic [OPC_W-1:0] OP_ADDRPC = 4'b1110;

  typedef struct packed {
    logic rdStb;
    logic wrStb;
    logic pcRelStb;
  } ctrl_t;
endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic             instrValid,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            strobes
);
  always_comb begin
    strobes = '0;
    if (instrValid) begin
      case (opcode)
        OP_LDREG:  strobes.rdStb    = 1'b1;
        OP_STREG:  strobes.wrStb    = 1'b1;
        OP_ADDRPC: strobes.pcRelStb = 1'b1;
        default:   strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/ldst_dp.sv
module ldst_dp
  import ldst_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int RW    = RIDX_W,
  parameter int OFFB  = OFFB_W,
  parameter int OFFP  = OFFP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrl_t          strobes,
  input  logic [11:0]    fields,
  input  logic [W-1:0]   nextPc,
  input  logic [W-1:0]   regDataA,
  input  logic [W-1:0]   regDataB,
  input  logic [W-1:0]   memRdata,
  output logic [W-1:0]   memAddr,
  output logic [W-1:0]   memWdata,
  output logic           wbEn,
  output logic [RW-1:0]  wbReg,
  output logic [W-1:0]   wbData,
  output logic           ccNeg,
  output logic           ccZero,
  output logic           ccPos
);
  localparam int DST_LO = OFFP;

  logic [W-1:0] baseOff;
  logic [W-1:0] pcOff;
  logic [W-1:0] pcSum;
  logic         wbEnQ;
  logic         fromMemQ;
  logic [RW-1:0] wbRegQ;
  logic [W-1:0] pcRelQ;

  assign baseOff  = {{(W-OFFB){fields[OFFB-1]}}, fields[OFFB-1:0]};
  assign pcOff    = {{(W-OFFP){fields[OFFP-1]}}, fields[OFFP-1:0]};
  assign memAddr  = regDataA + baseOff;
  assign memWdata = regDataB;
  assign pcSum    = nextPc + pcOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEnQ    <= 1'b0;
      fromMemQ <= 1'b0;
      wbRegQ   <= '0;
      pcRelQ   <= '0;
    end else begin
      wbEnQ    <= strobes.rdStb | strobes.pcRelStb;
      fromMemQ <= strobes.rdStb;
      if (strobes.rdStb | strobes.pcRelStb)
        wbRegQ <= fields[DST_LO+RW-1:DST_LO];
      if (strobes.pcRelStb)
        pcRelQ <= pcSum;
    end
  end

  assign wbEn   = wbEnQ;
  assign wbReg  = wbRegQ;
  assign wbData = fromMemQ ? memRdata : pcRelQ;
  assign ccNeg  = wbData[W-1];
  assign ccZero = (wbData == '0);
  assign ccPos  = !ccNeg && !ccZero;

  assert_load_dest_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStb |=> wbEn && (wbReg == $past(fields[DST_LO+RW-1:DST_LO])))
    else $error("load writeback missing or misdirected");

  assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |=> !wbEn)
    else $error("store produced a writeback");

  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> ($countones({ccNeg, ccZero, ccPos}) == 1))
    else $error("condition flags not one-hot");
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   nextPc,
  output logic [RIDX_W-1:0] regSelA,
  output logic [RIDX_W-1:0] regSelB,
  input  logic [XLEN-1:0]   regDataA,
  input  logic [XLEN-1:0]   regDataB,
  output logic [XLEN-1:0]   memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [XLEN-1:0]   memWdata,
  input  logic [XLEN-1:0]   memRdata,
  output logic              wbEn,
  output logic [RIDX_W-1:0] wbReg,
  output logic [XLEN-1:0]   wbData,
  output logic              ccNeg,
  output logic              ccZero,
  output logic              ccPos
);
  ctrl_t strobes;
  logic [OPC_W-1:0] opcode;

  assign opcode  = instr[XLEN-1:XLEN-OPC_W];
  assign regSelA = instr[8:6];
  assign regSelB = instr[11:9];

  ldst_ctrl ctrl_i (
    .instrValid(instrValid),
    .opcode    (opcode),
    .strobes   (strobes)
  );

  ldst_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .fields  (instr[11:0]),
    .nextPc  (nextPc),
    .regDataA(regDataA),
    .regDataB(regDataB),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .wbEn    (wbEn),
    .wbReg   (wbReg),
    .wbData  (wbData),
    .ccNeg   (ccNeg),
    .ccZero  (ccZero),
    .ccPos   (ccPos)
  );

  assign memRead  = strobes.rdStb;
  assign memWrite = strobes.wrStb;

  assert_pcrel_no_mem_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == OP_ADDRPC) |-> (!memRead && !memWrite))
    else $error("PC-relative op touched memory");

  assert_pcrel_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == OP_ADDRPC) |=>
      (wbEn && wbData == $past(nextPc) + {{(XLEN-9){$past(instr[8])}}, $past(instr[8:0])}))
    else $error("PC-relative writeback value wrong");

  assert_other_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!instrValid || !(opcode == OP_LDREG || opcode == OP_STREG || opcode == OP_ADDRPC))
      |-> (!memRead && !memWrite))
    else $error("memory strobe on idle or undecoded cycle");

  assert_other_no_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!instrValid || !(opcode == OP_LDREG || opcode == OP_ADDRPC)) |=> !wbEn)
    else $error("writeback without a producing issue");

  assert_wb_has_issue_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(instrValid))
    else $error("writeback not tied to previous issue");
endmodule

// File: tb/ldst_agen_tb_top.sv
`timescale 1ns/1ps
module ldst_agen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] nextPc = '0;
  logic [2:0] regSelA, regSelB;
  logic [15:0] regDataA, regDataB;
  logic [15:0] memAddr, memWdata, wbData;
  logic memRead, memWrite, wbEn, ccNeg, ccZero, ccPos;
  logic [15:0] memRdata = '0;
  logic [2:0] wbReg;

  logic [15:0] rf [8];
  logic [15:0] bmem [256];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign regDataA = rf[regSelA];
  assign regDataB = rf[regSelB];

  always @(posedge clk) begin
    if (memRead) memRdata <= bmem[memAddr[7:0]];
    if (memWrite) bmem[memAddr[7:0]] <= memWdata;
  end

  ldst_agen dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr), .nextPc(nextPc),
    .regSelA(regSelA), .regSelB(regSelB), .regDataA(regDataA), .regDataB(regDataB),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite), .memWdata(memWdata),
    .memRdata(memRdata), .wbEn(wbEn), .wbReg(wbReg), .wbData(wbData),
    .ccNeg(ccNeg), .ccZero(ccZero), .ccPos(ccPos)
  );

  function automatic logic [15:0] sx6(input logic [5:0] v);
    return {{10{v[5]}}, v};
  endfunction
  function automatic logic [15:0] sx9(input logic [8:0] v);
    return {{7{v[8]}}, v};
  endfunction
  function automatic logic [2:0] flagsOf(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [15:0] ins, input logic [15:0] pc);
    logic [3:0] op = ins[15:12];
    logic [15:0] a6 = rf[ins[8:6]] + sx6(ins[5:0]);
    logic [15:0] v9 = pc + sx9(ins[8:0]);
    logic [15:0] expW = '0;
    @(negedge clk);
    instrValid = 1'b1; instr = ins; nextPc = pc;
    #1;
    case (op)
      4'b0110: begin
        chk("R2 selA", {29'd0, regSelA}, {29'd0, ins[8:6]});
        chk("R2 rd/wr", {30'd0, memRead, memWrite}, 32'd2);
        chk("R2/R6 addr", {16'd0, memAddr}, {16'd0, a6});
        expW = bmem[a6[7:0]];
      end
      4'b0111: begin
        chk("R4 selB", {29'd0, regSelB}, {29'd0, ins[11:9]});
        chk("R4 rd/wr", {30'd0, memRead, memWrite}, 32'd1);
        chk("R4/R6 addr", {16'd0, memAddr}, {16'd0, a6});
        chk("R4 wdata", {16'd0, memWdata}, {16'd0, rf[ins[11:9]]});
      end
      4'b1110: chk("R5 no mem", {30'd0, memRead, memWrite}, 32'd0);
      default: chk("R8 no mem", {30'd0, memRead, memWrite}, 32'd0);
    endcase
    @(negedge clk);
    instrValid = 1'b0;
    #1;
    case (op)
      4'b0110: begin
        chk("R3 wb", {16'd0, wbEn, wbReg, 12'd0}, {16'd0, 1'b1, ins[11:9], 12'd0});
        chk("R3 data", {16'd0, wbData}, {16'd0, expW});
        chk("R7 flags", {29'd0, ccNeg, ccZero, ccPos}, {29'd0, flagsOf(expW)});
      end
      4'b1110: begin
        chk("R5 wb", {16'd0, wbEn, wbReg, 12'd0}, {16'd0, 1'b1, ins[11:9], 12'd0});
        chk("R5/R6 data", {16'd0, wbData}, {16'd0, v9});
        chk("R7 flags", {29'd0, ccNeg, ccZero, ccPos}, {29'd0, flagsOf(v9)});
      end
      4'b0111: chk("R4 no wb", {31'd0, wbEn}, 32'd0);
      default: chk("R8 no wb", {31'd0, wbEn}, 32'd0);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] seedDummy;
    seedDummy = 16'($urandom(32'd20250));
    for (int i = 0; i < 8; i++) rf[i] = 16'($urandom);
    for (int i = 0; i < 256; i++) bmem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    chk("R1 reset", {29'd0, memRead, memWrite, wbEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 after release", {29'd0, memRead, memWrite, wbEn}, 32'd0);

    // R6 directed: most negative and most positive offsets, wrap, zero result
    rf[5] = 16'h0005;
    runOne({4'b0110, 3'd2, 3'd5, 6'b100000}, 16'h0000);
    runOne({4'b0110, 3'd3, 3'd5, 6'b011111}, 16'h0000);
    runOne({4'b1110, 3'd1, 9'h100}, 16'h0010);
    runOne({4'b1110, 3'd4, 9'h1FD}, 16'h0003);
    runOne({4'b1110, 3'd6, 9'h0FF}, 16'h7F00);
    runOne({4'b1110, 3'd1, 9'd9}, 16'h3004);
    rf[5] = 16'hFFF0;
    runOne({4'b0111, 3'd5, 3'd5, 6'b010100}, 16'h0000);
    runOne({4'b0110, 3'd7, 3'd5, 6'b010100}, 16'h0000);
    chk("R4 stored word", {16'd0, wbData}, {16'd0, 16'hFFF0});

    // R9: load then PC-relative in consecutive cycles
    begin
      logic [15:0] ldIns = {4'b0110, 3'd2, 3'd0, 6'd3};
      logic [15:0] exLd;
      rf[0] = 16'h0040;
      exLd = bmem[8'h43];
      @(negedge clk);
      instrValid = 1'b1; instr = ldIns; nextPc = 16'h0;
      @(negedge clk);
      instr = {4'b1110, 3'd5, 9'h1FF}; nextPc = 16'h1000;
      #1;
      chk("R9 load wb", {15'd0, wbEn, wbReg, 13'd0}, {15'd0, 1'b1, 3'd2, 13'd0});
      chk("R9 load data", {16'd0, wbData}, {16'd0, exLd});
      @(negedge clk);
      instrValid = 1'b0;
      #1;
      chk("R9 pcrel wb", {15'd0, wbEn, wbReg, 13'd0}, {15'd0, 1'b1, 3'd5, 13'd0});
      chk("R9 pcrel data", {16'd0, wbData}, {16'd0, 16'h0FFF});
    end

    // R8: idle valid-low cycle with a decodable word
    @(negedge clk);
    instrValid = 1'b0; instr = {4'b0110, 12'h0};
    #1;
    chk("R8 invalid no mem", {30'd0, memRead, memWrite}, 32'd0);
    @(negedge clk); #1;
    chk("R8 invalid no wb", {31'd0, wbEn}, 32'd0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ins = 16'($urandom);
      int pick = int'($urandom % 4);
      if (pick == 0) ins[15:12] = 4'b0110;
      else if (pick == 1) ins[15:12] = 4'b0111;
      else if (pick == 2) ins[15:12] = 4'b1110;
      else begin
        while (ins[15:12] == 4'b0110 || ins[15:12] == 4'b0111 || ins[15:12] == 4'b1110)
          ins[15:12] = 4'($urandom);
      end
      for (int r = 0; r < 8; r++) rf[r] = 16'($urandom);
      runOne(ins, 16'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule